// File: doc/BRIEF.md
# Partial-Sum Widening and Activation Unit

This block sits directly after a binary-weight convolution engine and does the two arithmetic steps that the engine leaves behind. In accumulate mode it takes four signed 16-bit partial convolution sums, packed two per 32-bit operand word. It sign-extends each one and adds all four into a signed 32-bit running sum. Software issues this step once every sixteen input maps, so the narrow 16-bit partials never overflow. The running sum then grows to its full 32-bit width.

In activate mode it takes a finished signed 32-bit sum and produces an unsigned 8-bit activation. Negative sums become zero, as a ReLU requires. A non-negative sum is shifted right by a programmable amount and then clamped to 255. An accumulator clear input starts a fresh running sum at the beginning of each output map. Every accepted operation returns its result exactly one cycle after it is accepted.

Top module: `psum_act_unit`

## Requirements
- R1: After reset, out_valid is 0, result is 0 and the running sum is 0.
- R2: An accumulate operation (op_sel = 0, in_valid = 1) reads four signed two's-complement 16-bit lanes: opnd_a[15:0], opnd_a[31:16], opnd_b[15:0] and opnd_b[31:16]. It sign-extends each lane to 32 bits, adds all four to the running sum, and returns the new running sum on result.
- R3: If acc_clear is 1 during an accumulate operation, the running sum is treated as 0 before the lanes are added, so result equals the lane total alone.
- R4: The running sum wraps modulo 2^32 in two's complement; no saturation is applied.
- R5: An activate operation (op_sel = 1, in_valid = 1) reads opnd_a as a signed 32-bit sum. If that sum is negative, result is 0. In activate mode, result[31:8] is always 0.
- R6: For a non-negative sum, the activate operation shifts the sum right by shift_amt (0 to 31). It returns the shifted value if that value is at most 255, and 255 otherwise.
- R7: An activate operation leaves the running sum unchanged; acc_clear has no effect during an activate operation.
- R8: out_valid is 1 in exactly the cycle after a cycle with in_valid = 1, and 0 otherwise.
- R9: While in_valid is 0, all other inputs are ignored; the running sum and result both hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| op_sel | input | 1 | 0 = accumulate, 1 = activate |
| acc_clear | input | 1 | Start a new running sum (accumulate only) |
| opnd_a | input | 32 | Lanes 0/1 (accumulate) or the sum to activate |
| opnd_b | input | 32 | Lanes 2/3 (accumulate) |
| shift_amt | input | 5 | Right-shift amount for activation |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Running sum, or zero-extended activation |

## Verification
Accumulation is tried with small positive lanes, then with their negatives. A correct sign extension brings the sum back to zero; a zero-extension bug leaves a large positive residue. Extreme lanes 0x7FFF and 0x8000 show which lane is mapped to which position. A long run of maximal lanes pushes the sum past 2^31, which separates wrap-around from saturation.

For activation, the bench uses negative sums and values just below and above 255. It also uses a shift of 31 and a shift large enough to keep the top bit. Together these separate the ReLU, the shift direction and amount, and the clamp.

Interleaved activate and idle cycles, with acc_clear and junk operands held high, show whether the running sum is disturbed when it must not be.

// File: rtl/psa_pkg.sv
package psa_pkg;

    // Operation codes carried on op_sel.
    typedef enum logic {
        OP_ACCUM    = 1'b0,
        OP_ACTIVATE = 1'b1
    } psa_op_e;

    // Number of packed partial-sum lanes across both operand words.
    localparam int unsigned PSA_LANES = 4;

endpackage

// File: rtl/psa_lane_adder.sv
module psa_lane_adder #(
    parameter int unsigned LANE_W = 16,
    parameter int unsigned LANES  = 4,
    parameter int unsigned ACC_W  = 32
) (
    input  logic [LANES*LANE_W-1:0] lanes,
    output logic [ACC_W-1:0]        total
);

    logic [ACC_W-1:0] ext [LANES];

    // Sign-extend every lane to the accumulator width.
    for (genvar g = 0; g < LANES; g++) begin : g_ext
        logic [LANE_W-1:0] lane_v;
        assign lane_v = lanes[g*LANE_W +: LANE_W];
        assign ext[g] = {{(ACC_W-LANE_W){lane_v[LANE_W-1]}}, lane_v};
    end

    always_comb begin
        total = '0;
        for (int i = 0; i < LANES; i++) begin
            total = total + ext[i];
        end
    end

endmodule

// File: rtl/psa_relu_scaler.sv
module psa_relu_scaler #(
    parameter int unsigned ACC_W   = 32,
    parameter int unsigned ACT_W   = 8,
    parameter int unsigned SHIFT_W = 5
) (
    input  logic [ACC_W-1:0]   sum_in,
    input  logic [SHIFT_W-1:0] shift,
    output logic [ACT_W-1:0]   act
);

    localparam logic [ACC_W-1:0] ACT_MAX = ACC_W'((1 << ACT_W) - 1);

    logic             is_neg;
    logic [ACC_W-1:0] shifted;

    assign is_neg  = sum_in[ACC_W-1];
    // Only used for non-negative sums, where the arithmetic and logical shifts agree.
    assign shifted = sum_in >> shift;

    always_comb begin
        if (is_neg) begin
            act = '0;
        end else if (shifted > ACT_MAX) begin
            act = ACT_MAX[ACT_W-1:0];
        end else begin
            act = shifted[ACT_W-1:0];
        end
    end

endmodule

// File: rtl/psum_act_unit.sv
module psum_act_unit #(
    parameter int unsigned LANE_W  = 16,
    parameter int unsigned ACC_W   = 32,
    parameter int unsigned ACT_W   = 8,
    parameter int unsigned SHIFT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               op_sel,
    input  logic               acc_clear,
    input  logic [ACC_W-1:0]   opnd_a,
    input  logic [ACC_W-1:0]   opnd_b,
    input  logic [SHIFT_W-1:0] shift_amt,
    output logic               out_valid,
    output logic [ACC_W-1:0]   result
);

    import psa_pkg::*;

    localparam int unsigned LANE_BITS = PSA_LANES * LANE_W;

    typedef struct packed {
        logic             vld;
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] res;
    } state_t;

    state_t st_d, st_q;

    logic [LANE_BITS-1:0] lanes_in;
    logic [ACC_W-1:0]     lane_total;
    logic [ACT_W-1:0]     act_val;
    logic [ACC_W-1:0]     acc_base;
    psa_op_e              op;

    assign op       = psa_op_e'(op_sel);
    assign lanes_in = LANE_BITS'({opnd_b, opnd_a});

    psa_lane_adder #(
        .LANE_W (LANE_W),
        .LANES  (PSA_LANES),
        .ACC_W  (ACC_W)
    ) u_lanes (
        .lanes (lanes_in),
        .total (lane_total)
    );

    psa_relu_scaler #(
        .ACC_W   (ACC_W),
        .ACT_W   (ACT_W),
        .SHIFT_W (SHIFT_W)
    ) u_act (
        .sum_in (opnd_a),
        .shift  (shift_amt),
        .act    (act_val)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        acc_base = acc_clear ? '0 : st_q.acc;
        if (in_valid) begin
            if (op == OP_ACCUM) begin
                st_d.acc = acc_base + lane_total;
                st_d.res = acc_base + lane_total;
            end else begin
                st_d.res = {{(ACC_W-ACT_W){1'b0}}, act_val};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;

endmodule

// File: rtl/psum_act_unit_chk.sv
module psum_act_unit_chk #(
    parameter int unsigned ACC_W   = 32,
    parameter int unsigned ACT_W   = 8,
    parameter int unsigned SHIFT_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               op_sel,
    input logic               acc_clear,
    input logic [ACC_W-1:0]   opnd_a,
    input logic [ACC_W-1:0]   opnd_b,
    input logic [SHIFT_W-1:0] shift_amt,
    input logic               out_valid,
    input logic [ACC_W-1:0]   result
);

    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_no_spurious_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    p_act_narrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel) |=> (result[ACC_W-1:ACT_W] == '0));

    p_relu_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel && opnd_a[ACC_W-1]) |=> (result == '0));

    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_sel && acc_clear && opnd_a == '0 && opnd_b == '0) |=> (result == '0));

    p_shift_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel && !opnd_a[ACC_W-1] && shift_amt == '0 && opnd_a <= ACC_W'(255))
        |=> (result == $past(opnd_a)));

endmodule

bind psum_act_unit psum_act_unit_chk #(
    .ACC_W   (ACC_W),
    .ACT_W   (ACT_W),
    .SHIFT_W (SHIFT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .acc_clear (acc_clear),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .shift_amt (shift_amt),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/tb_psum_act_unit.sv
module tb_psum_act_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        op_sel = 1'b0;
    logic        acc_clear = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  shift_amt = '0;
    logic        out_valid;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    logic [31:0] model_acc = '0;

    always #2 clk = ~clk;

    psum_act_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .acc_clear(acc_clear), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .shift_amt(shift_amt), .out_valid(out_valid), .result(result)
    );

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] exp_act(input logic [31:0] s, input logic [4:0] sh);
        logic [31:0] t;
        if (s[31]) return 32'd0;
        t = s >> sh;
        return (t > 32'd255) ? 32'd255 : t;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one operation; returns after the result register has updated.
    task automatic issue(input logic op, input logic clr, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] sh);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; acc_clear = clr;
        opnd_a = a; opnd_b = b; shift_amt = sh;
        @(posedge clk); #1;
        if (op == 1'b0) begin
            model_acc = (clr ? 32'd0 : model_acc) + sx(a[15:0]) + sx(a[31:16])
                        + sx(b[15:0]) + sx(b[31:16]);
        end
    endtask

    task automatic idle_cycle(input logic [31:0] junk);
        @(negedge clk);
        in_valid = 1'b0; op_sel = junk[0]; acc_clear = 1'b1;
        opnd_a = junk; opnd_b = ~junk; shift_amt = junk[4:0];
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 result", result, 32'd0);
        issue(1'b0, 1'b0, 32'd0, 32'd0, 5'd0);
        check("R1 sum", result, 32'd0);
    endtask

    task automatic t_accumulate();
        issue(1'b0, 1'b1, {16'd2, 16'd1}, {16'd4, 16'd3}, 5'd0);
        check("R3 clear start", result, 32'd10);
        check("R8 valid", {31'd0, out_valid}, 32'd1);
        issue(1'b0, 1'b0, {16'hFFFE, 16'hFFFF}, {16'hFFFC, 16'hFFFD}, 5'd0);
        check("R2 negative lanes", result, 32'd0);
        issue(1'b0, 1'b0, {16'h8000, 16'h7FFF}, {16'h0000, 16'h7FFF}, 5'd0);
        check("R2 extreme lanes", result, model_acc);
        issue(1'b0, 1'b0, {16'h0000, 16'h8000}, {16'h8000, 16'h0001}, 5'd0);
        check("R2 mixed lanes", result, model_acc);
        issue(1'b0, 1'b1, {16'h0000, 16'h0000}, {16'h0005, 16'h0000}, 5'd0);
        check("R3 clear discards", result, 32'd5);
    endtask

    task automatic t_wrap();
        issue(1'b0, 1'b1, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 5'd0);
        for (int i = 0; i < 16384; i++) begin
            issue(1'b0, 1'b0, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 5'd0);
        end
        check("R4 wrap value", result, model_acc);
        check("R4 wrapped negative", {31'd0, result[31]}, 32'd1);
    endtask

    task automatic t_activate();
        issue(1'b1, 1'b0, 32'hFFFF_FF00, 32'd0, 5'd0);
        check("R5 negative", result, 32'd0);
        issue(1'b1, 1'b0, 32'h8000_0000, 32'd0, 5'd3);
        check("R5 most negative", result, 32'd0);
        issue(1'b1, 1'b0, 32'd1000, 32'd0, 5'd2);
        check("R6 shift 2", result, exp_act(32'd1000, 5'd2));
        issue(1'b1, 1'b0, 32'd1024, 32'd0, 5'd2);
        check("R6 saturate", result, 32'd255);
        issue(1'b1, 1'b0, 32'd255, 32'd0, 5'd0);
        check("R6 edge 255", result, 32'd255);
        issue(1'b1, 1'b0, 32'd256, 32'd0, 5'd0);
        check("R6 edge 256", result, 32'd255);
        issue(1'b1, 1'b0, 32'h7FFF_FFFF, 32'd0, 5'd31);
        check("R6 shift 31", result, 32'd0);
        issue(1'b1, 1'b0, 32'h7FFF_FFFF, 32'd0, 5'd24);
        check("R6 shift 24", result, 32'd127);
        issue(1'b1, 1'b0, 32'd77, 32'hFFFF_FFFF, 5'd0);
        check("R6 pass through", result, 32'd77);
    endtask

    task automatic t_act_keeps_sum();
        issue(1'b0, 1'b1, {16'd0, 16'd9}, 32'd0, 5'd0);
        issue(1'b1, 1'b1, 32'd100, 32'd0, 5'd0);
        check("R7 act result", result, 32'd100);
        issue(1'b0, 1'b0, 32'd0, 32'd0, 5'd0);
        check("R7 sum kept", result, 32'd9);
    endtask

    task automatic t_idle();
        issue(1'b0, 1'b0, {16'd0, 16'd3}, 32'd0, 5'd0);
        idle_cycle(32'hA5A5_5A5A);
        check("R8 no valid", {31'd0, out_valid}, 32'd0);
        check("R9 result held", result, 32'd12);
        idle_cycle(32'h1234_8765);
        issue(1'b0, 1'b0, 32'd0, 32'd0, 5'd0);
        check("R9 sum held", result, 32'd12);
        check("R8 valid again", {31'd0, out_valid}, 32'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset_pre();
    end

    task automatic t_reset_pre();
        check("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_accumulate();
        t_wrap();
        t_activate();
        t_act_keeps_sum();
        t_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule